// File: doc/BRIEF.md
# Selectable-Period Watchdog Reset Timer

This block watches a host for signs of life. The host must send a kick pulse before a chosen number of timebase ticks goes by. If it does not, the block raises a system reset. A 2-bit period code picks one of three unequal timeouts or turns the watchdog off. The code comes from storage that keeps its value across power cycles, so the block treats it as a static input.

The reset output also serves the power-up path and the low-supply path. While the asynchronous power-up reset is low, or while the low-supply hold request is high, reset is asserted. Reset then stays asserted for a fixed number of ticks after that condition clears. Every watchdog timeout uses the same hold interval, and the watchdog counter then restarts from zero.

Timeouts and the hold interval are parameters given in timebase ticks, so a bench can use short values. The default, with a 1 ms tick, gives 1400, 600 and 200 ticks.

Top module: `wdog_reset_top`

## Requirements
- R1: With period code 2'b00, reset asserts after LONG_TICKS ticks with no kick, and not after LONG_TICKS-1 ticks.
- R2: With period code 2'b01, reset asserts after MID_TICKS ticks with no kick, and not one tick earlier.
- R3: With period code 2'b10, reset asserts after SHORT_TICKS ticks with no kick, and not one tick earlier.
- R4: With period code 2'b11 the watchdog is off: no number of ticks causes a reset.
- R5: A kick clears the watchdog count, so a full period of ticks is needed again before a timeout.
- R6: Reset is asserted while arst_n is low and for HOLD_TICKS ticks after it rises, then released.
- R7: Reset is asserted in the cycle after hold_req rises, stays asserted while hold_req is high, and stays asserted for HOLD_TICKS ticks after hold_req falls.
- R8: After a timeout, reset is held for HOLD_TICKS ticks, and the count then restarts from zero.
- R9: rst_out_n is always the inverse of rst_out.
- R10: When a kick and the tick that would expire the period fall in the same cycle, the kick wins and no reset occurs.
- R11: A kick during the hold interval has no effect; the hold still lasts HOLD_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| tick | input | 1 | One-cycle timebase pulse |
| kick | input | 1 | One-cycle restart pulse from the host |
| period_sel | input | 2 | Timeout code: 00 long, 01 mid, 10 short, 11 off |
| hold_req | input | 1 | Low-supply reset request, active high |
| rst_out | output | 1 | Reset output, active high |
| rst_out_n | output | 1 | Reset output, active low |

## Verification
Two functions can meet in one cycle: the tick that completes the period and a host kick. The bench runs the short period up to one tick before expiry. It then drives tick and kick together in a single cycle. The result passes only if reset stays low and a full further period is then needed before reset asserts. A second collision is a kick that arrives during the hold interval. There the hold must keep its full length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      PER_LONG  = 2'b00,
      PER_MID   = 2'b01,
      PER_SHORT = 2'b10,
      PER_OFF   = 2'b11
   } period_e;

   typedef enum logic {
      ST_HOLD = 1'b0,
      ST_RUN  = 1'b1
   } wdt_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel
   import wdt_pkg::*;
#(
   parameter int unsigned LONG_TICKS  = 1400,
   parameter int unsigned MID_TICKS   = 600,
   parameter int unsigned SHORT_TICKS = 200,
   parameter int unsigned CW          = 11
) (
   input  logic [1:0]    code,
   output logic [CW-1:0] limit,
   output logic          enable
);

   localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_TICKS);
   localparam logic [CW-1:0] LIM_MID   = CW'(MID_TICKS);
   localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_TICKS);

   generate
      if (LONG_TICKS < 1 || MID_TICKS < 1 || SHORT_TICKS < 1) begin : g_bad_zero
         $error("wdt_limit_sel: every timeout must be at least one tick");
      end
      if ((1 << CW) <= LONG_TICKS || (1 << CW) <= MID_TICKS || (1 << CW) <= SHORT_TICKS)
      begin : g_bad_width
         $error("wdt_limit_sel: CW too narrow for the timeouts");
      end
   endgenerate

   always_comb begin
      enable = 1'b1;
      unique case (period_e'(code))
         PER_LONG:  limit = LIM_LONG;
         PER_MID:   limit = LIM_MID;
         PER_SHORT: limit = LIM_SHORT;
         default: begin
            limit  = LIM_LONG;
            enable = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/wdt_kick_counter.sv
module wdt_kick_counter #(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          run,
   input  logic          enable,
   input  logic          tick,
   input  logic          kick,
   input  logic [CW-1:0] limit,
   output logic          expire
);

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (cnt_q == limit - 1'b1);
   assign expire = run && enable && tick && !kick && at_end;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
      end else if (!run || !enable || kick || expire) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_count_bound_r1: assert property (@(posedge clk) disable iff (!arst_n)
      (run && enable) |-> (cnt_q < limit));

   p_off_no_expire_r4: assert property (@(posedge clk) disable iff (!arst_n)
      !enable |=> (cnt_q == '0));

   p_kick_clears_r5: assert property (@(posedge clk) disable iff (!arst_n)
      kick |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_hold_timer.sv
module wdt_hold_timer #(
   parameter int unsigned HOLD_TICKS = 200,
   parameter int unsigned HW         = 8
) (
   input  logic clk,
   input  logic arst_n,
   input  logic active,
   input  logic restart,
   input  logic tick,
   output logic done
);

   localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

   logic [HW-1:0] hcnt_q;

   generate
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("wdt_hold_timer: HOLD_TICKS must be at least one");
      end
   endgenerate

   assign done = active && !restart && tick && (hcnt_q == LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hcnt_q <= '0;
      end else if (!active || restart || done) begin
         hcnt_q <= '0;
      end else if (tick) begin
         hcnt_q <= hcnt_q + 1'b1;
      end
   end

   p_hold_bound_r6: assert property (@(posedge clk) disable iff (!arst_n)
      hcnt_q <= LAST);

   p_restart_clears_r7: assert property (@(posedge clk) disable iff (!arst_n)
      restart |=> (hcnt_q == '0));

endmodule

// File: rtl/wdog_reset_top.sv
module wdog_reset_top
   import wdt_pkg::*;
#(
   parameter int unsigned LONG_TICKS  = 1400,
   parameter int unsigned MID_TICKS   = 600,
   parameter int unsigned SHORT_TICKS = 200,
   parameter int unsigned HOLD_TICKS  = 200
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       tick,
   input  logic       kick,
   input  logic [1:0] period_sel,
   input  logic       hold_req,
   output logic       rst_out,
   output logic       rst_out_n
);

   localparam int unsigned MAX_T = max3(LONG_TICKS, MID_TICKS, SHORT_TICKS);
   localparam int unsigned CW    = $clog2(MAX_T + 1);
   localparam int unsigned HW    = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

   wdt_state_e    state_q, state_d;
   logic          rst_q;
   logic [CW-1:0] limit;
   logic          enable;
   logic          expire;
   logic          hold_done;

   wdt_limit_sel #(
      .LONG_TICKS (LONG_TICKS),
      .MID_TICKS  (MID_TICKS),
      .SHORT_TICKS(SHORT_TICKS),
      .CW         (CW)
   ) u_limit (
      .code  (period_sel),
      .limit (limit),
      .enable(enable)
   );

   wdt_kick_counter #(
      .CW(CW)
   ) u_count (
      .clk   (clk),
      .arst_n(arst_n),
      .run   (state_q == ST_RUN),
      .enable(enable),
      .tick  (tick),
      .kick  (kick),
      .limit (limit),
      .expire(expire)
   );

   wdt_hold_timer #(
      .HOLD_TICKS(HOLD_TICKS),
      .HW        (HW)
   ) u_hold (
      .clk    (clk),
      .arst_n (arst_n),
      .active (state_q == ST_HOLD),
      .restart(hold_req),
      .tick   (tick),
      .done   (hold_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HOLD: if (hold_done)          state_d = ST_RUN;
         default: if (hold_req || expire) state_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= ST_HOLD;
         rst_q   <= 1'b1;
      end else begin
         state_q <= state_d;
         rst_q   <= (state_d == ST_HOLD);
      end
   end

   assign rst_out   = rst_q;
   assign rst_out_n = ~rst_q;

   p_off_never_expires_r4: assert property (@(posedge clk) disable iff (!arst_n)
      (period_sel == 2'b11) |-> !expire);

   p_hold_req_resets_r7: assert property (@(posedge clk) disable iff (!arst_n)
      hold_req |=> rst_out);

   p_timeout_resets_r8: assert property (@(posedge clk) disable iff (!arst_n)
      expire |=> rst_out);

   p_kick_wins_r10: assert property (@(posedge clk) disable iff (!arst_n)
      (kick && !rst_out && !hold_req) |=> !rst_out);

   p_hold_ignores_kick_r11: assert property (@(posedge clk) disable iff (!arst_n)
      (rst_out && !hold_done) |=> rst_out);

endmodule

// File: tb/wdog_reset_top_tb.sv
module wdog_reset_top_tb;

   localparam int LONG_T  = 20;
   localparam int MID_T   = 9;
   localparam int SHORT_T = 4;
   localparam int HOLD_T  = 5;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       tick = 1'b0;
   logic       kick = 1'b0;
   logic [1:0] period_sel = 2'b11;
   logic       hold_req = 1'b0;
   logic       rst_out, rst_out_n;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   wdog_reset_top #(
      .LONG_TICKS (LONG_T),
      .MID_TICKS  (MID_T),
      .SHORT_TICKS(SHORT_T),
      .HOLD_TICKS (HOLD_T)
   ) u_dut (
      .clk       (clk),
      .arst_n    (arst_n),
      .tick      (tick),
      .kick      (kick),
      .period_sel(period_sel),
      .hold_req  (hold_req),
      .rst_out   (rst_out),
      .rst_out_n (rst_out_n)
   );

   task automatic chk(input logic exp, input string tag);
      total++;
      if (rst_out !== exp) begin
         bad++;
         $display("FAIL %s: rst_out=%b expected %b", tag, rst_out, exp);
      end
      total++;
      if (rst_out_n !== ~exp) begin
         bad++;
         $display("FAIL R9 (%s): rst_out_n=%b expected %b", tag, rst_out_n, ~exp);
      end
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic do_kick();
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
   endtask

   task automatic power_up(input logic [1:0] code);
      @(negedge clk) arst_n = 1'b0;
      period_sel = code;
      repeat (2) @(negedge clk);
      chk(1'b1, "R6 reset during arst");
      arst_n = 1'b1;
      do_ticks(HOLD_T - 1);
      chk(1'b1, "R6 hold one tick short");
      do_ticks(1);
      chk(1'b0, "R6 release after hold");
   endtask

   task automatic test_period(input logic [1:0] code, input int n, input string tag);
      power_up(code);
      do_ticks(n - 1);
      chk(1'b0, tag);
      do_ticks(1);
      chk(1'b1, tag);
   endtask

   task automatic test_off();
      power_up(2'b11);
      do_ticks(3 * LONG_T);
      chk(1'b0, "R4 disabled code never resets");
   endtask

   task automatic test_kick();
      power_up(2'b10);
      do_ticks(SHORT_T - 1);
      do_kick();
      do_ticks(SHORT_T - 1);
      chk(1'b0, "R5 kick restarts period");
      do_ticks(1);
      chk(1'b1, "R5 timeout after full period from kick");
   endtask

   task automatic test_after_timeout();
      // Begins just after a short-period timeout (reset already high).
      do_ticks(HOLD_T - 1);
      chk(1'b1, "R8 hold after timeout");
      do_kick();
      chk(1'b1, "R11 kick during hold ignored");
      do_ticks(1);
      chk(1'b0, "R11 hold length unchanged by kick");
      do_ticks(SHORT_T - 1);
      chk(1'b0, "R8 counter restarted from zero");
      do_ticks(1);
      chk(1'b1, "R8 next timeout after full period");
   endtask

   task automatic test_hold_req();
      power_up(2'b10);
      @(negedge clk) hold_req = 1'b1;
      @(negedge clk);
      chk(1'b1, "R7 reset next cycle after request");
      do_ticks(3 * HOLD_T);
      chk(1'b1, "R7 reset held while request high");
      @(negedge clk) hold_req = 1'b0;
      do_ticks(HOLD_T - 1);
      chk(1'b1, "R7 hold after request falls");
      do_ticks(1);
      chk(1'b0, "R7 release after hold");
   endtask

   task automatic test_collide();
      power_up(2'b10);
      do_ticks(SHORT_T - 1);
      @(negedge clk) begin
         tick = 1'b1;
         kick = 1'b1;
      end
      @(negedge clk) begin
         tick = 1'b0;
         kick = 1'b0;
      end
      chk(1'b0, "R10 kick beats expiring tick");
      do_ticks(SHORT_T - 1);
      chk(1'b0, "R10 count cleared by colliding kick");
      do_ticks(1);
      chk(1'b1, "R10 timeout after full period");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      test_period(2'b00, LONG_T, "R1 long period");
      test_period(2'b01, MID_T, "R2 mid period");
      test_period(2'b10, SHORT_T, "R3 short period");
      test_after_timeout();
      test_off();
      test_kick();
      test_hold_req();
      test_collide();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule